// File: doc/BRIEF.md
# Byte SEC-DED Hamming Codec

This block guards one data byte with a 13-bit single-error-correcting, double-error-detecting Hamming codeword. It has two paths that are independent of each other and share one clock. The encode path takes a byte with a valid strobe and returns, one clock later, the codeword that goes to storage. The decode path takes a codeword read back from storage, which may be corrupted, with its own valid strobe. One clock later it returns the repaired byte, the error syndrome and one of three verdicts: clean, corrected or uncorrectable.

Codeword positions are numbered E0 to E12. E1 to E12 form the classic Hamming layout. The check bits sit at the power-of-two positions 1, 2, 4 and 8. The data bits D1 to D8 fill positions 3, 5, 6, 7, 9, 10, 11 and 12 in ascending order. E0 holds an extra overall parity bit that separates single errors from double ones. On both ports E0 is the most significant bit and E12 the least significant. On the byte ports D1 is the most significant bit.

The data width is a parameter. The number of check bits and the position map are derived from it, so the default byte width gives the 13-bit layout above. Reset is asynchronous and active-low.

Top module: `sd_codec`

## Requirements
- R1: The check bits are computed as E1 = D1^D2^D4^D5^D7, E2 = D1^D3^D4^D6^D7, E4 = D2^D3^D4^D8 and E8 = D5^D6^D7^D8. The data bits sit at E3, E5, E6, E7, E9, E10, E11 and E12 in that order. Byte 0xCE gives codeword 13'h079E.
- R2: Every codeword the encoder emits has even parity over all 13 bits, because E0 is the even parity of E1 to E12.
- R3: The encoder presents its codeword and a valid pulse on the clock edge after an accepted byte. While its input strobe is low, its codeword output holds its value.
- R4: An uncorrupted codeword decodes to its byte, with syndrome 0 and only the clean flag set.
- R5: The syndrome has E8 as its most significant bit and E1 as its least significant bit. A single flipped bit at position p in 1..12 gives syndrome p. That bit is inverted before the data is extracted, so the original byte is returned and only the corrected flag is set.
- R6: A flip of E0 alone gives syndrome 0 and overall parity failure. The byte is returned unchanged and only the corrected flag is set.
- R7: A nonzero syndrome with good overall parity sets only the uncorrectable flag. No bit is inverted: the byte is read directly from the received data positions, and the syndrome still equals the XOR of the flipped positions.
- R8: A syndrome above 12 together with a parity failure sets only the uncorrectable flag and inverts no bit.
- R9: The decoder presents its results and a valid pulse one clock after an accepted codeword. While its input strobe is low, its data, syndrome and flags hold. Whenever its valid output is high, exactly one flag is set.
- R10: While reset is held, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both paths |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_vld_i | input | 1 | Byte on enc_data_i is to be encoded |
| enc_data_i | input | 8 | Byte to encode, D1 in the MSB |
| enc_vld_o | output | 1 | enc_cw_o was updated on this edge |
| enc_cw_o | output | 13 | Codeword, E0 in the MSB, E12 in the LSB |
| dec_vld_i | input | 1 | Codeword on dec_cw_i is to be decoded |
| dec_cw_i | input | 13 | Received codeword, E0 in the MSB |
| dec_vld_o | output | 1 | Decoder results were updated on this edge |
| dec_data_o | output | 8 | Repaired byte, D1 in the MSB |
| dec_syn_o | output | 4 | Syndrome, E8 weight in the MSB |
| dec_clean_o | output | 1 | No error was seen |
| dec_fixed_o | output | 1 | A single error was corrected |
| dec_fatal_o | output | 1 | The error cannot be corrected |

## Verification
The assertions check on every cycle that the emitted codewords have even parity, that the results appear one cycle after a strobe and hold without one, and that the verdict flags are one-hot. They also check that a clean verdict comes only with a zero syndrome and that an out-of-range syndrome is always reported as uncorrectable. Whether the check-bit equations and the position map are right, and whether the correct byte comes back, only the bench's scenarios can show. It encodes all 256 bytes and replays each codeword with every single flip and with random flip pairs. It also applies directed triple flips that drive the syndrome above 12.

// File: rtl/sd_pkg.sv
package sd_pkg;

  // smallest count of check bits p with 2^p >= data + p + 1
  function automatic int chk_bits(input int dw);
    for (int p = 1; p < 31; p++) begin
      if ((1 << p) >= dw + p + 1) return p;
    end
    return 31;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // codeword position (1-based) holding data bit k (1-based)
  function automatic int data_pos(input int k);
    int cnt;
    cnt = 0;
    for (int p = 1; p < 4096; p++) begin
      if (!is_pow2(p)) begin
        cnt++;
        if (cnt == k) return p;
      end
    end
    return 0;
  endfunction

  typedef enum logic [1:0] {
    DEC_CLEAN = 2'd0,
    DEC_FIXED = 2'd1,
    DEC_FATAL = 2'd2
  } dec_kind_e;

endpackage

// File: rtl/sd_checkgen.sv
// Parity tree: bit j is the XOR of every position whose index has bit j set.
// With zeros at the check positions it yields check bits; over a received
// vector it yields the syndrome directly.
module sd_checkgen
  import sd_pkg::*;
#(
  parameter int N  = 12,
  parameter int PW = 4
) (
  input  logic [N:1]    pos_i,
  output logic [PW-1:0] chk_o
);

  for (genvar j = 0; j < PW; j++) begin : g_chk
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int p = 1; p <= N; p++) begin
        if (((p >> j) & 1) == 1) acc = acc ^ pos_i[p];
      end
    end
    assign chk_o[j] = acc;
  end

endmodule

// File: rtl/sd_encoder.sv
module sd_encoder
  import sd_pkg::*;
#(
  parameter  int DW = 8,
  localparam int PW = chk_bits(DW),
  localparam int N  = DW + PW,
  localparam int CW = N + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [DW-1:0] data_i,
  output logic          vld_o,
  output logic [CW-1:0] cw_o
);

  logic [N:1]    spread;
  logic [N:1]    full;
  logic [PW-1:0] chk;
  logic [CW-1:0] cw_d;
  logic          vld_q;
  logic [CW-1:0] cw_q;

  // place data bits at the non power-of-two positions
  always_comb begin
    spread = '0;
    for (int k = 1; k <= DW; k++) spread[data_pos(k)] = data_i[DW-k];
  end

  sd_checkgen #(.N(N), .PW(PW)) u_gen (
    .pos_i (spread),
    .chk_o (chk)
  );

  // next state: insert check bits, add overall parity, flip to port order
  always_comb begin
    full = spread;
    for (int j = 0; j < PW; j++) full[1 << j] = chk[j];
    for (int i = 1; i <= N; i++) cw_d[N-i] = full[i];
    cw_d[N] = ^full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      cw_q  <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) cw_q <= cw_d;
    end
  end

  assign vld_o = vld_q;
  assign cw_o  = cw_q;

endmodule

// File: rtl/sd_decoder.sv
module sd_decoder
  import sd_pkg::*;
#(
  parameter  int DW = 8,
  localparam int PW = chk_bits(DW),
  localparam int N  = DW + PW,
  localparam int CW = N + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [CW-1:0] cw_i,
  output logic          vld_o,
  output logic [DW-1:0] data_o,
  output logic [PW-1:0] syn_o,
  output logic [2:0]    flags_o   // {fatal, fixed, clean}
);

  logic [N:1]    rx;
  logic [N:1]    rep;
  logic [PW-1:0] syn;
  logic          par_err;
  dec_kind_e     kind;
  logic [DW-1:0] data_d;
  logic [2:0]    flags_d;

  logic          vld_q;
  logic [DW-1:0] data_q;
  logic [PW-1:0] syn_q;
  logic [2:0]    flags_q;

  always_comb begin
    for (int i = 1; i <= N; i++) rx[i] = cw_i[N-i];
  end

  sd_checkgen #(.N(N), .PW(PW)) u_syn (
    .pos_i (rx),
    .chk_o (syn)
  );

  assign par_err = ^cw_i;

  // classify and repair
  always_comb begin
    rep = rx;
    if (syn == '0) begin
      kind = par_err ? DEC_FIXED : DEC_CLEAN;
    end else if (par_err && (syn <= PW'(N))) begin
      kind = DEC_FIXED;
      for (int p = 1; p <= N; p++) begin
        if (syn == PW'(p)) rep[p] = ~rx[p];
      end
    end else begin
      kind = DEC_FATAL;
    end
    for (int k = 1; k <= DW; k++) data_d[DW-k] = rep[data_pos(k)];
    unique case (kind)
      DEC_CLEAN: flags_d = 3'b001;
      DEC_FIXED: flags_d = 3'b010;
      default:   flags_d = 3'b100;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      data_q  <= '0;
      syn_q   <= '0;
      flags_q <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        data_q  <= data_d;
        syn_q   <= syn;
        flags_q <= flags_d;
      end
    end
  end

  assign vld_o   = vld_q;
  assign data_o  = data_q;
  assign syn_o   = syn_q;
  assign flags_o = flags_q;

endmodule

// File: rtl/sd_codec.sv
module sd_codec
  import sd_pkg::*;
#(
  parameter  int DW = 8,
  localparam int PW = chk_bits(DW),
  localparam int CW = DW + PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enc_vld_i,
  input  logic [DW-1:0] enc_data_i,
  output logic          enc_vld_o,
  output logic [CW-1:0] enc_cw_o,
  input  logic          dec_vld_i,
  input  logic [CW-1:0] dec_cw_i,
  output logic          dec_vld_o,
  output logic [DW-1:0] dec_data_o,
  output logic [PW-1:0] dec_syn_o,
  output logic          dec_clean_o,
  output logic          dec_fixed_o,
  output logic          dec_fatal_o
);

  logic [2:0] flags;

  sd_encoder #(.DW(DW)) u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (enc_vld_i),
    .data_i (enc_data_i),
    .vld_o  (enc_vld_o),
    .cw_o   (enc_cw_o)
  );

  sd_decoder #(.DW(DW)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_i   (dec_vld_i),
    .cw_i    (dec_cw_i),
    .vld_o   (dec_vld_o),
    .data_o  (dec_data_o),
    .syn_o   (dec_syn_o),
    .flags_o (flags)
  );

  assign dec_clean_o = flags[0];
  assign dec_fixed_o = flags[1];
  assign dec_fatal_o = flags[2];

endmodule

// File: rtl/sd_codec_chk.sv
module sd_codec_chk #(
  parameter int DW = 8,
  parameter int PW = 4,
  parameter int CW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enc_vld_i,
  input logic          enc_vld_o,
  input logic [CW-1:0] enc_cw_o,
  input logic          dec_vld_i,
  input logic          dec_vld_o,
  input logic [DW-1:0] dec_data_o,
  input logic [PW-1:0] dec_syn_o,
  input logic          dec_clean_o,
  input logic          dec_fixed_o,
  input logic          dec_fatal_o
);

  localparam int N = CW - 1;

  assert_cw_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enc_vld_o |-> (^enc_cw_o == 1'b0));

  assert_enc_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enc_vld_i |=> enc_vld_o);

  assert_enc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_vld_i |=> (!enc_vld_o && $stable(enc_cw_o)));

  assert_clean_syn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_clean_o |-> (dec_syn_o == '0));

  assert_fixed_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fixed_o |-> (dec_syn_o <= PW'(N)));

  assert_wide_syn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld_o && (dec_syn_o > PW'(N))) |-> dec_fatal_o);

  assert_dec_lat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_i |=> dec_vld_o);

  assert_dec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld_i |=> (!dec_vld_o && $stable(dec_data_o) && $stable(dec_syn_o)
                    && $stable({dec_fatal_o, dec_fixed_o, dec_clean_o})));

  assert_flags_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_o |-> ($countones({dec_fatal_o, dec_fixed_o, dec_clean_o}) == 1));

endmodule

bind sd_codec sd_codec_chk #(.DW(DW), .PW(PW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enc_vld_i   (enc_vld_i),
  .enc_vld_o   (enc_vld_o),
  .enc_cw_o    (enc_cw_o),
  .dec_vld_i   (dec_vld_i),
  .dec_vld_o   (dec_vld_o),
  .dec_data_o  (dec_data_o),
  .dec_syn_o   (dec_syn_o),
  .dec_clean_o (dec_clean_o),
  .dec_fixed_o (dec_fixed_o),
  .dec_fatal_o (dec_fatal_o)
);

// File: tb/tb_sd_codec.sv
`timescale 1ns/1ps
module tb_sd_codec;

  logic        clk;
  logic        rst_n;
  logic        enc_vld_i;
  logic [7:0]  enc_data_i;
  logic        enc_vld_o;
  logic [12:0] enc_cw_o;
  logic        dec_vld_i;
  logic [12:0] dec_cw_i;
  logic        dec_vld_o;
  logic [7:0]  dec_data_o;
  logic [3:0]  dec_syn_o;
  logic        dec_clean_o;
  logic        dec_fixed_o;
  logic        dec_fatal_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  sd_codec dut (
    .clk(clk), .rst_n(rst_n),
    .enc_vld_i(enc_vld_i), .enc_data_i(enc_data_i),
    .enc_vld_o(enc_vld_o), .enc_cw_o(enc_cw_o),
    .dec_vld_i(dec_vld_i), .dec_cw_i(dec_cw_i),
    .dec_vld_o(dec_vld_o), .dec_data_o(dec_data_o), .dec_syn_o(dec_syn_o),
    .dec_clean_o(dec_clean_o), .dec_fixed_o(dec_fixed_o), .dec_fatal_o(dec_fatal_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // reference encoder from the requirement equations (R1, R2)
  function automatic logic [12:0] ref_enc(input logic [7:0] d);
    logic d1, d2, d3, d4, d5, d6, d7, d8, r1, r2, r3, r4;
    logic [11:0] e;
    {d1, d2, d3, d4, d5, d6, d7, d8} = d;
    r1 = d1 ^ d2 ^ d4 ^ d5 ^ d7;
    r2 = d1 ^ d3 ^ d4 ^ d6 ^ d7;
    r3 = d2 ^ d3 ^ d4 ^ d8;
    r4 = d5 ^ d6 ^ d7 ^ d8;
    e = {r1, r2, d1, r3, d2, d3, d4, r4, d5, d6, d7, d8};
    return {^e, e};
  endfunction

  // data read straight from the data positions (E3,E5..E7,E9..E12)
  function automatic logic [7:0] raw_data(input logic [12:0] cw);
    return {cw[9], cw[7], cw[6], cw[5], cw[3], cw[2], cw[1], cw[0]};
  endfunction

  // flip codeword position p (0..12)
  function automatic logic [12:0] flip(input logic [12:0] cw, input int p);
    logic [12:0] r;
    r = cw;
    r[12-p] = ~r[12-p];
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic encode(input logic [7:0] d, output logic [12:0] cw);
    @(negedge clk);
    enc_data_i = d;
    enc_vld_i  = 1'b1;
    @(negedge clk);
    enc_vld_i = 1'b0;
    check("R3", "enc valid", {31'd0, enc_vld_o}, 32'd1);
    cw = enc_cw_o;
  endtask

  task automatic decode(input logic [12:0] cw);
    @(negedge clk);
    dec_cw_i  = cw;
    dec_vld_i = 1'b1;
    @(negedge clk);
    dec_vld_i = 1'b0;
  endtask

  function automatic logic [31:0] flags();
    return {29'd0, dec_fatal_o, dec_fixed_o, dec_clean_o};
  endfunction

  task automatic expect_dec(input string req, input logic [7:0] d,
                            input logic [3:0] syn, input logic [2:0] fl);
    check(req, "dec valid", {31'd0, dec_vld_o}, 32'd1);
    check(req, "data",      {24'd0, dec_data_o}, {24'd0, d});
    check(req, "syndrome",  {28'd0, dec_syn_o}, {28'd0, syn});
    check(req, "flags",     flags(), {29'd0, fl});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [12:0] cw, bad, hold_cw;
    logic [7:0]  hold_d;
    logic [3:0]  hold_s;
    logic [31:0] hold_f;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; enc_vld_i = 1'b0; enc_data_i = '0;
    dec_vld_i = 1'b0; dec_cw_i = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "enc outputs", {18'd0, enc_vld_o, enc_cw_o}, 32'd0);
    check("R10", "dec outputs",
          {15'd0, dec_vld_o, dec_data_o, dec_syn_o, dec_fatal_o, dec_fixed_o, dec_clean_o}, 32'd0);
    rst_n = 1'b1;

    // R1: directed example byte
    encode(8'hCE, cw);
    check("R1", "0xCE codeword", {19'd0, cw}, {19'd0, 13'h079E});

    // R6 / R5 directed syndrome example: E6 flipped gives 0110
    decode(flip(cw, 6));
    expect_dec("R5", 8'hCE, 4'd6, 3'b010);

    // R8: triple flips driving the syndrome above 12
    decode(flip(flip(flip(cw, 1), 4), 8));
    expect_dec("R8", 8'hCE, 4'd13, 3'b100);
    decode(flip(flip(flip(cw, 2), 4), 8));
    expect_dec("R8", 8'hCE, 4'd14, 3'b100);

    // R3 / R9: hold while strobes are low
    hold_cw = enc_cw_o;
    hold_d = dec_data_o; hold_s = dec_syn_o; hold_f = flags();
    @(negedge clk);
    enc_data_i = 8'h35; dec_cw_i = 13'h1FFF;
    @(negedge clk);
    check("R3", "enc hold", {18'd0, enc_vld_o, enc_cw_o}, {18'd0, 1'b0, hold_cw});
    check("R9", "dec hold valid", {31'd0, dec_vld_o}, 32'd0);
    check("R9", "dec hold data", {20'd0, dec_data_o, dec_syn_o}, {20'd0, hold_d, hold_s});
    check("R9", "dec hold flags", flags(), hold_f);

    // sweep every byte
    for (int b = 0; b < 256; b++) begin
      encode(b[7:0], cw);
      check("R1", "codeword", {19'd0, cw}, {19'd0, ref_enc(b[7:0])});
      check("R2", "parity", {31'd0, ^cw}, 32'd0);
      decode(cw);
      expect_dec("R4", b[7:0], 4'd0, 3'b001);
      decode(flip(cw, 0));
      expect_dec("R6", b[7:0], 4'd0, 3'b010);
      for (int p = 1; p <= 12; p++) begin
        decode(flip(cw, p));
        expect_dec("R5", b[7:0], p[3:0], 3'b010);
      end
      for (int n = 0; n < 3; n++) begin
        int a, c;
        a = int'($urandom % 13);
        c = int'(($urandom % 12) + 1);
        c = (a + c) % 13;
        bad = flip(flip(cw, a), c);
        decode(bad);
        expect_dec("R7", raw_data(bad), 4'(a ^ c), 3'b100);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule